// File: doc/BRIEF.md
# Serial Frame Receive Controller

This block sequences the receive side of a serial link controller. Once software arms it, it waits for a begin-of-frame strobe from the line decoder. It then packs the decoded bits into bytes and checks the address result supplied by an external matcher. Accepted bytes go to a receive FIFO through a one-byte write port. The CRC is not computed here. The trailing CRC bytes are stripped instead: every assembled byte is held back by as many bytes as the selected CRC is long, so the CRC bytes are still in the holdback when the frame ends and never reach the FIFO.

The block also decides which end conditions software sees. A frame that ends before any byte has been written is dropped silently. A collision seen in carrier-sense/collision-detect mode after payload has reached the FIFO aborts reception and disarms the receiver. A collision earlier than that only sends the receiver back to searching. A clean end of frame raises a sticky done flag and disarms the receiver. In hardware-acknowledge mode it also raises a one-cycle request to send an acknowledgment, except when the frame carried a group (broadcast or multicast) address. `ADDR_BYTES` must be 1 or 2, so that the address decision is made before the first FIFO write.

Top module: `frame_rx_ctrl`

## Requirements
- R1: After reset, rxEnable, rxDone, rxAbort, rxGroup, ackReq, irqReq and fifoWrEn are all 0.
- R2: While rxEnable is 0, the bit, end-of-frame, collision and begin-of-frame inputs have no effect. A swSetEnable pulse makes rxEnable 1 on the next cycle. While armed but before a begin-of-frame strobe, bits and end-of-frame strobes cause no write and no status change.
- R3: Bits are accepted only on cycles with bitValid high. Each byte is assembled least significant bit first from 8 accepted bits, and bytes are written to the FIFO in arrival order.
- R4: The matcher results are sampled on the cycle that carries the last bit of byte ADDR_BYTES-1 of the frame. If addrHit is 0 there, the frame is dropped: no byte is written, no flag changes and rxEnable stays 1.
- R5: With crc32Sel low at begin-of-frame, byte k is written when byte k+2 completes, so the first write appears 24 accepted bits after the strobe. With crc32Sel high, byte k is written when byte k+4 completes, so the first write appears 40 bits after. fifoWrEn is high for one cycle, in the cycle after the completing bit.
- R6: The last 2 bytes (16-bit CRC) or the last 4 bytes (32-bit CRC) of a frame are never written.
- R7: An end-of-frame strobe before any byte of the frame has been written causes no status change, and rxEnable stays 1.
- R8: An end-of-frame strobe after at least one write sets rxDone and clears rxEnable on the next cycle.
- R9: With csmaMode high, a collision after at least one write sets rxAbort and clears rxEnable, and rxDone does not change. A collision takes priority over an end-of-frame strobe in the same cycle.
- R10: With csmaMode high, a collision before any write abandons the frame with no flag set and rxEnable left at 1. With csmaMode low, collisions are ignored and the frame continues.
- R11: rxGroup takes addrGroup when a frame is accepted. When rxDone is set with hwAckMode high and rxGroup low, ackReq is high for exactly that one cycle.
- R12: rxDone and rxAbort stay set until a clrDone or clrAbort pulse (a set in the same cycle wins). irqReq equals rxDone AND doneIrqEn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| swSetEnable | input | 1 | Software pulse that arms the receiver |
| clrDone | input | 1 | Software pulse that clears rxDone |
| clrAbort | input | 1 | Software pulse that clears rxAbort |
| doneIrqEn | input | 1 | Interrupt enable for rxDone |
| csmaMode | input | 1 | Carrier-sense/collision-detect mode |
| hwAckMode | input | 1 | Hardware acknowledgment mode |
| crc32Sel | input | 1 | 1 selects 32-bit CRC, 0 selects 16-bit; sampled at begin-of-frame |
| bitIn | input | 1 | Decoded receive bit |
| bitValid | input | 1 | bitIn is valid this cycle |
| bofDetect | input | 1 | Begin-of-frame flag detected (pulse) |
| eofDetect | input | 1 | End-of-frame detected (pulse) |
| collision | input | 1 | Collision detected (pulse) |
| addrHit | input | 1 | Address matcher: frame addressed to this station |
| addrGroup | input | 1 | Address matcher: broadcast or multicast address |
| fifoWrEn | output | 1 | Receive FIFO write strobe |
| fifoWrData | output | 8 | Receive FIFO write data |
| rxEnable | output | 1 | Receiver armed |
| rxDone | output | 1 | Sticky frame-received flag |
| rxAbort | output | 1 | Sticky receive-aborted flag |
| ackReq | output | 1 | One-cycle request to send an acknowledgment |
| rxGroup | output | 1 | Last accepted frame used a group address |
| irqReq | output | 1 | Interrupt request |

## Verification
The bench goes after the holdback boundaries. Frames of exactly the CRC length produce no write. The first write must land at bit 24 or bit 40, and a design with a holdback one byte too short or too long would leak a CRC byte or lose a payload byte. Frames are ended by a collision on both sides of the first write, in both collision modes. A design that keys the decision on frame start rather than on the first write would raise a spurious abort, or fail to disarm. Group-addressed frames in acknowledgment mode, address misses, and gaps in bitValid show up as a stray ackReq, a leaked write or a mis-assembled byte, since every output is compared with a reference model on each cycle.

// File: rtl/frame_rx_pkg.sv
package frame_rx_pkg;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_HUNT = 2'd1,
    ST_ADDR = 2'd2,
    ST_LOAD = 2'd3
  } rxState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic startFrame;  // clear assembler and holdback, latch CRC length
    logic takeBit;     // a valid bit this cycle belongs to the frame
  } dpCtrl_t;

endpackage

// File: rtl/frame_rx_datapath.sv
module frame_rx_datapath
  import frame_rx_pkg::*;
#(
  parameter int DATA_W          = 8,
  parameter int SHORT_CRC_BYTES = 2,
  parameter int LONG_CRC_BYTES  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctrl,
  input  logic              crc32Sel,
  input  logic              bitIn,
  input  logic              bitValid,
  output logic              byteDone,
  output logic              payloadSeen,
  output logic              fifoWrEn,
  output logic [DATA_W-1:0] fifoWrData
);

  localparam int CNT_W    = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int HOLD_MAX = (LONG_CRC_BYTES > SHORT_CRC_BYTES) ? LONG_CRC_BYTES : SHORT_CRC_BYTES;
  localparam int HCNT_W   = $clog2(HOLD_MAX + 1);

  logic [CNT_W-1:0]  bitCnt;
  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] newByte;
  logic [DATA_W-1:0] holdQ [HOLD_MAX];
  logic [HCNT_W-1:0] holdCnt;
  logic              longMode;
  logic              holdFull;
  logic [DATA_W-1:0] oldest;
  logic              bitTake;

  assign bitTake  = ctrl.takeBit & bitValid;
  assign newByte  = {bitIn, shiftReg[DATA_W-1:1]};   // first bit ends up in bit 0
  assign byteDone = bitTake & (bitCnt == CNT_W'(DATA_W - 1));
  assign holdFull = longMode ? (holdCnt == HCNT_W'(LONG_CRC_BYTES))
                             : (holdCnt == HCNT_W'(SHORT_CRC_BYTES));
  assign oldest   = longMode ? holdQ[LONG_CRC_BYTES-1] : holdQ[SHORT_CRC_BYTES-1];

  // Bit assembler and holdback fill level
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt      <= '0;
      shiftReg    <= '0;
      holdCnt     <= '0;
      longMode    <= 1'b0;
      payloadSeen <= 1'b0;
      fifoWrEn    <= 1'b0;
      fifoWrData  <= '0;
    end else begin
      fifoWrEn <= 1'b0;
      if (ctrl.startFrame) begin
        bitCnt      <= '0;
        holdCnt     <= '0;
        longMode    <= crc32Sel;
        payloadSeen <= 1'b0;
      end else if (bitTake) begin
        shiftReg <= newByte;
        if (byteDone) begin
          bitCnt <= '0;
          if (holdFull) begin
            fifoWrEn    <= 1'b1;
            fifoWrData  <= oldest;
            payloadSeen <= 1'b1;
          end else begin
            holdCnt <= holdCnt + HCNT_W'(1);
          end
        end else begin
          bitCnt <= bitCnt + CNT_W'(1);
        end
      end
    end
  end

  // Holdback shift register: entry 0 is the newest byte
  genvar gi;
  generate
    for (gi = 0; gi < HOLD_MAX; gi++) begin : g_hold
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          holdQ[gi] <= '0;
        end else if (byteDone) begin
          if (gi == 0) holdQ[gi] <= newByte;
          else         holdQ[gi] <= holdQ[(gi > 0) ? gi - 1 : 0];
        end
      end
    end
  endgenerate

endmodule

// File: rtl/frame_rx_control.sv
module frame_rx_control
  import frame_rx_pkg::*;
#(
  parameter int ADDR_BYTES = 1
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    swSetEnable,
  input  logic    clrDone,
  input  logic    clrAbort,
  input  logic    csmaMode,
  input  logic    hwAckMode,
  input  logic    bofDetect,
  input  logic    eofDetect,
  input  logic    collision,
  input  logic    addrHit,
  input  logic    addrGroup,
  input  logic    byteDone,
  input  logic    payloadSeen,
  output dpCtrl_t ctrl,
  output logic    rxEnable,
  output logic    rxDone,
  output logic    rxAbort,
  output logic    ackReq,
  output logic    rxGroup
);

  localparam int ABYTE_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;

  rxState_t           state;
  logic [ABYTE_W-1:0] addrCnt;
  logic               inFrame;
  logic               collKill;
  logic               lastAddr;

  assign inFrame  = (state == ST_ADDR) || (state == ST_LOAD);
  assign collKill = inFrame & collision & csmaMode;
  assign lastAddr = (addrCnt == ABYTE_W'(ADDR_BYTES - 1));

  assign ctrl.startFrame = (state == ST_HUNT) & bofDetect;
  assign ctrl.takeBit    = inFrame & ~collKill & ~eofDetect;
  assign rxEnable        = (state != ST_OFF);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_OFF;
      addrCnt <= '0;
      rxDone  <= 1'b0;
      rxAbort <= 1'b0;
      ackReq  <= 1'b0;
      rxGroup <= 1'b0;
    end else begin
      ackReq <= 1'b0;
      if (clrDone)  rxDone  <= 1'b0;
      if (clrAbort) rxAbort <= 1'b0;
      unique case (state)
        ST_OFF: begin
          if (swSetEnable) state <= ST_HUNT;
        end
        ST_HUNT: begin
          if (bofDetect) begin
            state   <= ST_ADDR;
            addrCnt <= '0;
          end
        end
        default: begin  // ST_ADDR, ST_LOAD
          if (collKill) begin
            if (payloadSeen) begin
              rxAbort <= 1'b1;
              state   <= ST_OFF;
            end else begin
              state <= ST_HUNT;
            end
          end else if (eofDetect) begin
            if (payloadSeen) begin
              rxDone <= 1'b1;
              ackReq <= hwAckMode & ~rxGroup;
              state  <= ST_OFF;
            end else begin
              state <= ST_HUNT;
            end
          end else if (byteDone && state == ST_ADDR) begin
            if (lastAddr) begin
              if (addrHit) begin
                state   <= ST_LOAD;
                rxGroup <= addrGroup;
              end else begin
                state <= ST_HUNT;
              end
            end else begin
              addrCnt <= addrCnt + ABYTE_W'(1);
            end
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/frame_rx_ctrl.sv
module frame_rx_ctrl
  import frame_rx_pkg::*;
#(
  parameter int DATA_W          = 8,
  parameter int ADDR_BYTES      = 1,
  parameter int SHORT_CRC_BYTES = 2,
  parameter int LONG_CRC_BYTES  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              swSetEnable,
  input  logic              clrDone,
  input  logic              clrAbort,
  input  logic              doneIrqEn,
  input  logic              csmaMode,
  input  logic              hwAckMode,
  input  logic              crc32Sel,
  input  logic              bitIn,
  input  logic              bitValid,
  input  logic              bofDetect,
  input  logic              eofDetect,
  input  logic              collision,
  input  logic              addrHit,
  input  logic              addrGroup,
  output logic              fifoWrEn,
  output logic [DATA_W-1:0] fifoWrData,
  output logic              rxEnable,
  output logic              rxDone,
  output logic              rxAbort,
  output logic              ackReq,
  output logic              rxGroup,
  output logic              irqReq
);

  dpCtrl_t ctrl;
  logic    byteDone;
  logic    payloadSeen;

  frame_rx_control #(.ADDR_BYTES(ADDR_BYTES)) u_control (
    .clk        (clk),
    .rstN       (rstN),
    .swSetEnable(swSetEnable),
    .clrDone    (clrDone),
    .clrAbort   (clrAbort),
    .csmaMode   (csmaMode),
    .hwAckMode  (hwAckMode),
    .bofDetect  (bofDetect),
    .eofDetect  (eofDetect),
    .collision  (collision),
    .addrHit    (addrHit),
    .addrGroup  (addrGroup),
    .byteDone   (byteDone),
    .payloadSeen(payloadSeen),
    .ctrl       (ctrl),
    .rxEnable   (rxEnable),
    .rxDone     (rxDone),
    .rxAbort    (rxAbort),
    .ackReq     (ackReq),
    .rxGroup    (rxGroup)
  );

  frame_rx_datapath #(
    .DATA_W         (DATA_W),
    .SHORT_CRC_BYTES(SHORT_CRC_BYTES),
    .LONG_CRC_BYTES (LONG_CRC_BYTES)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .crc32Sel   (crc32Sel),
    .bitIn      (bitIn),
    .bitValid   (bitValid),
    .byteDone   (byteDone),
    .payloadSeen(payloadSeen),
    .fifoWrEn   (fifoWrEn),
    .fifoWrData (fifoWrData)
  );

  assign irqReq = rxDone & doneIrqEn;

endmodule

// File: rtl/frame_rx_checker.sv
module frame_rx_checker (
  input logic clk,
  input logic rstN,
  input logic clrDone,
  input logic clrAbort,
  input logic fifoWrEn,
  input logic rxEnable,
  input logic rxDone,
  input logic rxAbort,
  input logic ackReq,
  input logic rxGroup,
  input logic irqReq
);

  // Writes only happen while a frame is being loaded
  assert_write_while_armed_R5: assert property (@(posedge clk) disable iff (!rstN)
    fifoWrEn |-> rxEnable);

  // Once disarmed, no further write
  assert_no_write_when_off_R2: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> !fifoWrEn);

  assert_done_disarms_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxDone) |-> !rxEnable);

  assert_abort_disarms_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxAbort) |-> !rxEnable);

  assert_done_abort_exclusive_R9: assert property (@(posedge clk) disable iff (!rstN)
    !($rose(rxDone) && $rose(rxAbort)));

  assert_ack_needs_done_R11: assert property (@(posedge clk) disable iff (!rstN)
    ackReq |-> (rxDone && !rxGroup && !rxEnable));

  assert_ack_single_R11: assert property (@(posedge clk) disable iff (!rstN)
    ackReq |=> !ackReq);

  assert_done_sticky_R12: assert property (@(posedge clk) disable iff (!rstN)
    (rxDone && !clrDone) |=> rxDone);

  assert_abort_sticky_R12: assert property (@(posedge clk) disable iff (!rstN)
    (rxAbort && !clrAbort) |=> rxAbort);

  assert_irq_source_R12: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> rxDone);

endmodule

bind frame_rx_ctrl frame_rx_checker u_checker (.*);

// File: tb/tb_frame_rx_ctrl.sv
module tb_frame_rx_ctrl;

  localparam int ADDR_BYTES = 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic swSetEnable = 0, clrDone = 0, clrAbort = 0, doneIrqEn = 0;
  logic csmaMode = 0, hwAckMode = 0, crc32Sel = 0;
  logic bitIn = 0, bitValid = 0, bofDetect = 0, eofDetect = 0, collision = 0;
  logic addrHit = 0, addrGroup = 0;
  logic       fifoWrEn;
  logic [7:0] fifoWrData;
  logic rxEnable, rxDone, rxAbort, ackReq, rxGroup, irqReq;

  int testsRun = 0;
  int testsFailed = 0;
  int cyc = 0;
  bit finished = 0;

  frame_rx_ctrl dut (
    .clk(clk), .rstN(rstN), .swSetEnable(swSetEnable), .clrDone(clrDone),
    .clrAbort(clrAbort), .doneIrqEn(doneIrqEn), .csmaMode(csmaMode),
    .hwAckMode(hwAckMode), .crc32Sel(crc32Sel), .bitIn(bitIn), .bitValid(bitValid),
    .bofDetect(bofDetect), .eofDetect(eofDetect), .collision(collision),
    .addrHit(addrHit), .addrGroup(addrGroup), .fifoWrEn(fifoWrEn),
    .fifoWrData(fifoWrData), .rxEnable(rxEnable), .rxDone(rxDone),
    .rxAbort(rxAbort), .ackReq(ackReq), .rxGroup(rxGroup), .irqReq(irqReq)
  );

  always #10 clk = ~clk;   // 50 MHz

  // ---------------- reference model ----------------
  int      mState = 0;      // 0 off, 1 hunt, 2 address, 3 loading
  int      mBits = 0;
  int      mAddrN = 0;
  int      mDepth = 2;
  bit      mSeen = 0;
  bit [7:0] mCur = 0;
  bit [7:0] mHold [$];
  bit      eWr = 0, eDone = 0, eAbort = 0, eAck = 0, eGroup = 0;
  bit [7:0] eData = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rstN) begin
      mState = 0; mSeen = 0; mHold.delete();
      eWr = 0; eDone = 0; eAbort = 0; eAck = 0; eGroup = 0; eData = 0;
    end else begin
      eWr = 0; eAck = 0;
      if (clrDone)  eDone = 0;
      if (clrAbort) eAbort = 0;
      if (mState == 0) begin
        if (swSetEnable) mState = 1;
      end else if (mState == 1) begin
        if (bofDetect) begin
          mState = 2; mBits = 0; mAddrN = 0; mSeen = 0;
          mHold.delete();
          mDepth = crc32Sel ? 4 : 2;
        end
      end else begin
        if (collision && csmaMode) begin
          if (mSeen) begin eAbort = 1; mState = 0; end
          else mState = 1;
        end else if (eofDetect) begin
          if (mSeen) begin eDone = 1; eAck = hwAckMode && !eGroup; mState = 0; end
          else mState = 1;
        end else if (bitValid) begin
          mCur[mBits] = bitIn;
          mBits++;
          if (mBits == 8) begin
            mBits = 0;
            if (mHold.size() == mDepth) begin
              eWr = 1; eData = mHold.pop_front(); mSeen = 1;
            end
            mHold.push_back(mCur);
            if (mState == 2) begin
              mAddrN++;
              if (mAddrN == ADDR_BYTES) begin
                if (addrHit) begin mState = 3; eGroup = addrGroup; end
                else mState = 1;
              end
            end
          end
        end
      end
    end
  end

  // ---------------- checking ----------------
  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  int  wrCount = 0;
  int  ackCount = 0;
  int  firstWrCyc = -1;
  int  firstWrData = -1;
  bit  compareOn = 0;

  always @(negedge clk) begin
    if (compareOn) begin
      check(fifoWrEn == eWr, "R5", "fifoWrEn", int'(fifoWrEn), int'(eWr));
      if (eWr) check(fifoWrData == eData, "R3", "fifoWrData", int'(fifoWrData), int'(eData));
      check(rxEnable == (mState != 0), "R2", "rxEnable", int'(rxEnable), int'(mState != 0));
      check(rxDone == eDone, "R8", "rxDone", int'(rxDone), int'(eDone));
      check(rxAbort == eAbort, "R9", "rxAbort", int'(rxAbort), int'(eAbort));
      check(ackReq == eAck, "R11", "ackReq", int'(ackReq), int'(eAck));
      check(rxGroup == eGroup, "R11", "rxGroup", int'(rxGroup), int'(eGroup));
      check(irqReq == (eDone && doneIrqEn), "R12", "irqReq", int'(irqReq), int'(eDone && doneIrqEn));
      if (fifoWrEn) begin
        if (firstWrCyc < 0) begin firstWrCyc = cyc; firstWrData = int'(fifoWrData); end
        wrCount++;
      end
      if (ackReq) ackCount++;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1; tick(); sig = 1'b0;
  endtask

  task automatic sendByte(input bit [7:0] v, input bit gaps);
    for (int b = 0; b < 8; b++) begin
      bitIn = v[b]; bitValid = 1'b1; tick();
      if (gaps && b == 3) begin bitValid = 1'b0; bitIn = ~bitIn; tick(); end
    end
    bitValid = 1'b0;
  endtask

  int bofCyc = 0;

  // endKind: 0 end-of-frame, 1 collision; collMid: byte index before which a collision pulses (-1 none)
  task automatic runFrame(input int nBytes, input bit wide, input bit hit, input bit grp,
                          input int endKind, input int collMid, input bit gaps);
    wrCount = 0; ackCount = 0; firstWrCyc = -1; firstWrData = -1;
    crc32Sel = wide; addrHit = hit; addrGroup = grp;
    tick();
    bofDetect = 1'b1; tick(); bofDetect = 1'b0;
    bofCyc = cyc;
    crc32Sel = ~wide;   // sampled only at begin-of-frame
    for (int i = 0; i < nBytes; i++) begin
      if (i == collMid) pulse(collision);
      sendByte(8'h5A + 8'(17 * i), gaps);
    end
    if (endKind == 0) pulse(eofDetect); else pulse(collision);
    tick(); tick();
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      testsRun++; testsFailed++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  // ---------------- scenarios ----------------
  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    // R1 reset state
    check(!rxEnable, "R1", "rxEnable", int'(rxEnable), 0);
    check(!rxDone && !rxAbort, "R1", "flags", int'(rxDone) + int'(rxAbort), 0);
    check(!fifoWrEn && !ackReq && !irqReq && !rxGroup, "R1", "outputs",
          int'(fifoWrEn) + int'(ackReq) + int'(irqReq) + int'(rxGroup), 0);
    compareOn = 1;

    // R2 disabled: line activity ignored
    wrCount = 0;
    pulse(bofDetect);
    sendByte(8'hFF, 0); sendByte(8'h12, 0); sendByte(8'h34, 0);
    pulse(collision); pulse(eofDetect); tick();
    check(wrCount == 0 && !rxEnable && !rxDone && !rxAbort, "R2", "disabled activity",
          wrCount + int'(rxEnable) + int'(rxDone) + int'(rxAbort), 0);
    pulse(swSetEnable);
    check(rxEnable, "R2", "arm", int'(rxEnable), 1);
    sendByte(8'hC3, 0); pulse(eofDetect); tick();
    check(rxEnable && !rxDone && wrCount == 0, "R2", "armed before frame start",
          int'(rxEnable) * 10 + wrCount, 10);

    // R5/R6/R8/R11/R12: 16-bit CRC, unicast, acknowledgment requested
    hwAckMode = 1; doneIrqEn = 1;
    runFrame(6, 0, 1, 0, 0, -1, 0);
    check(wrCount == 4, "R6", "writes 16-bit frame", wrCount, 4);
    check(firstWrCyc - bofCyc == 24, "R5", "first write delay 16-bit", firstWrCyc - bofCyc, 24);
    check(firstWrData == 8'h5A, "R3", "first byte", firstWrData, 8'h5A);
    check(rxDone && !rxEnable, "R8", "done and disarmed", int'(rxDone) * 10 + int'(rxEnable), 10);
    check(ackCount == 1, "R11", "ack pulses", ackCount, 1);
    check(irqReq, "R12", "irq", int'(irqReq), 1);
    repeat (5) tick();
    check(rxDone, "R12", "done sticky", int'(rxDone), 1);
    pulse(clrDone); tick();
    check(!rxDone && !irqReq, "R12", "done cleared", int'(rxDone) + int'(irqReq), 0);

    // R5/R6/R11: 32-bit CRC, group address
    pulse(swSetEnable);
    runFrame(8, 1, 1, 1, 0, -1, 0);
    check(wrCount == 4, "R6", "writes 32-bit frame", wrCount, 4);
    check(firstWrCyc - bofCyc == 40, "R5", "first write delay 32-bit", firstWrCyc - bofCyc, 40);
    check(ackCount == 0, "R11", "no ack for group", ackCount, 0);
    check(rxGroup, "R11", "group status", int'(rxGroup), 1);
    pulse(clrDone);

    // R4 address miss
    pulse(swSetEnable);
    runFrame(5, 0, 0, 0, 0, -1, 0);
    check(wrCount == 0 && rxEnable && !rxDone, "R4", "miss dropped",
          wrCount * 100 + int'(rxEnable) * 10 + int'(rxDone), 10);

    // R7 runt frame, exactly CRC length (still armed from above)
    runFrame(2, 0, 1, 0, 0, -1, 0);
    check(wrCount == 0 && rxEnable && !rxDone, "R7", "runt dropped",
          wrCount * 100 + int'(rxEnable) * 10 + int'(rxDone), 10);
    runFrame(4, 1, 1, 0, 0, -1, 1);
    check(wrCount == 0 && rxEnable && !rxDone, "R7", "runt 32-bit dropped",
          wrCount * 100 + int'(rxEnable) * 10 + int'(rxDone), 10);

    // R10 early collision in collision-detect mode
    csmaMode = 1;
    runFrame(2, 0, 1, 0, 1, -1, 0);
    check(wrCount == 0 && rxEnable && !rxAbort, "R10", "early collision",
          wrCount * 100 + int'(rxEnable) * 10 + int'(rxAbort), 10);

    // R10 collision ignored outside collision-detect mode
    csmaMode = 0;
    runFrame(5, 0, 1, 0, 0, 3, 1);
    check(wrCount == 3 && rxDone && !rxAbort, "R10", "collision ignored",
          wrCount * 100 + int'(rxDone) * 10 + int'(rxAbort), 310);
    pulse(clrDone);

    // R9 late collision aborts
    csmaMode = 1; pulse(swSetEnable);
    runFrame(5, 0, 1, 0, 1, -1, 1);
    check(wrCount == 3, "R9", "writes before abort", wrCount, 3);
    check(rxAbort && !rxEnable && !rxDone, "R9", "abort state",
          int'(rxAbort) * 100 + int'(rxEnable) * 10 + int'(rxDone), 100);
    check(ackCount == 0, "R11", "no ack on abort", ackCount, 0);
    repeat (3) tick();
    check(rxAbort, "R12", "abort sticky", int'(rxAbort), 1);
    pulse(clrAbort); tick();
    check(!rxAbort, "R12", "abort cleared", int'(rxAbort), 0);

    tick();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule